// File: doc/BRIEF.md
# Buffered SPI Master Controller

This block is a serial peripheral interface master for an on-chip host. The host writes a byte together with a chip-select code into a one-entry holding register; the controller moves the byte into its shift register as soon as the shifter is free and clocks it out most significant bit first, sampling the MISO line on every bit so that each transmitted byte also yields one received byte. A byte written while a transfer is running waits in the holding register and starts the moment the current one finishes, so a steady host keeps the serial line busy without gaps.

Received bytes are queued in a four-entry receive FIFO, each entry tagged with the chip-select code that was active when it was captured. The host sees the oldest entry on its read port and pops it with a read strobe. Four flags report the buffer state: holding register empty, transmitter fully idle, receive data available and a sticky overrun. A divider sets the length of each half period of the serial clock, a gap counter inserts a programmable number of system clocks after every transfer, and a polarity input picks the idle level of the serial clock.

Top module: `spi_buf_master`

## Requirements
- R1: With `enable` high, a byte written into an empty holding register while the shifter is idle is loaded into the shifter on the next clock edge, which also drives `cs_n[wr_cs]` low; with `enable` low the byte stays in the holding register and no chip select goes low.
- R2: Every transfer is 8 bits, most significant bit first; MOSI changes only on the edge that returns the serial clock to its idle level, MISO is sampled on the edge that leaves it, and each half period lasts `max(clk_div,1)` system clocks, so a single transfer keeps its chip select low for 16 times that many clocks.
- R3: Whenever no chip select is low, `sck` equals `cpol`.
- R4: A byte written during a transfer waits; with `gap_dly` zero it starts on the same edge the previous transfer ends, so back-to-back transfers to one code keep that chip select low without a break.
- R5: A write that arrives while the holding register is full and is not being emptied on that edge is ignored and produces no transfer.
- R6: `thr_empty` goes low on the edge that captures a write and returns high on the edge that moves the byte into the shifter.
- R7: `tx_idle` is high only when the holding register and shifter are both empty; after the last transfer it rises exactly `gap_dly` clocks after the chip select goes high.
- R8: The receive FIFO holds four entries of received byte plus chip-select code, shows the oldest on `rd_data`/`rd_cs`, pops it on `rd_en`, and holds `rx_avail` high while any entry is unread.
- R9: A byte that arrives while four entries are unread and none is popped on that edge is discarded, the stored entries are kept, and `overrun` is set and held until a `stat_rd` strobe clears it.
- R10: During a transfer exactly the chip select selected by the code is low, and the chip-select lines change only while the serial clock is at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Allows the shifter to take bytes from the holding register |
| cpol | input | 1 | Idle level of the serial clock |
| clk_div | input | DIV_W | System clocks per serial clock half period (0 acts as 1) |
| gap_dly | input | GAP_W | System clocks inserted after every transfer |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| wr_cs | input | CS_W | Chip-select code for the byte |
| rd_en | input | 1 | Pops the oldest receive FIFO entry |
| stat_rd | input | 1 | Status read strobe, clears the overrun flag |
| rd_data | output | DATA_W | Received byte of the oldest FIFO entry |
| rd_cs | output | CS_W | Chip-select code of the oldest FIFO entry |
| thr_empty | output | 1 | Holding register empty |
| tx_idle | output | 1 | Holding register, shifter and gap all finished |
| rx_avail | output | 1 | At least one unread FIFO entry |
| overrun | output | 1 | Sticky receive overrun |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slaves |
| miso | input | 1 | Serial data from the selected slave |
| cs_n | output | 2**CS_W | Active-low chip selects, one per code |

## Verification
The properties assume that `cpol` changes only while `tx_idle` is high, that `clk_div` and `gap_dly` are held steady while a transfer or gap is running, and that writes start no earlier than two clocks after reset is released. The stimulus changes the configuration only after it has seen `tx_idle` high and waits several clocks after reset before the first write. The slave model in the bench drives MISO only on trailing serial clock edges, which keeps the sampled value settled at every leading edge.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;

  // Sequencer states of the transfer engine.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } xfer_st_e;

  // Next index of a circular buffer of the given depth.
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/spi_bm_div.sv
module spi_bm_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             half_tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] half_len;

  // A divisor of zero behaves as one.
  assign half_len  = (div == '0) ? DIV_W'(1) : div;
  assign half_tick = run && (cnt_q == half_len - DIV_W'(1));

  always_comb begin
    cnt_d = cnt_q + DIV_W'(1);
    if (!run || half_tick) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_bm_rxfifo.sv
module spi_bm_rxfifo #(
  parameter int DEPTH = 4,
  parameter int EW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [EW-1:0] push_ent,
  input  logic          pop,
  input  logic          clr_ovr,
  output logic [EW-1:0] head,
  output logic          not_empty,
  output logic          ovr
);
  import spi_bm_pkg::*;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovr_q, ovr_d;
  logic          full, do_pop, do_push;

  assign full      = (cnt_q == CW'(DEPTH));
  assign not_empty = (cnt_q != '0);
  assign do_pop    = pop && not_empty;
  // A full FIFO still accepts when an entry leaves on the same edge.
  assign do_push   = push && (!full || do_pop);
  assign head      = mem[rptr_q];
  assign ovr       = ovr_q;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    ovr_d  = ovr_q;
    if (do_push) wptr_d = PW'(ring_next(int'(wptr_q), DEPTH));
    if (do_pop)  rptr_d = PW'(ring_next(int'(rptr_q), DEPTH));
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
    if (clr_ovr) ovr_d = 1'b0;
    if (push && !do_push) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      ovr_q  <= ovr_d;
    end
  end

  // Storage cells carry no reset; each has its own write enable.
  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic cell_we;
    assign cell_we = do_push && (wptr_q == PW'(i));
    always_ff @(posedge clk) begin
      if (cell_we) mem[i] <= push_ent;
    end
  end

endmodule

// File: rtl/spi_bm_engine.sv
module spi_bm_engine #(
  parameter int DW    = 8,
  parameter int CSW   = 2,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             half_tick,
  input  logic             miso,
  input  logic [GAP_W-1:0] gap_dly,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic [CSW-1:0]   wr_cs,
  output logic             shifting,
  output logic             phase,
  output logic             mosi,
  output logic [CSW-1:0]   cur_cs,
  output logic             thr_empty,
  output logic             tx_idle,
  output logic             push,
  output logic [DW-1:0]    push_data,
  output logic [CSW-1:0]   push_cs
);
  import spi_bm_pkg::*;

  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  xfer_st_e         st_q, st_d;
  logic             hold_vld_q, hold_vld_d;
  logic [DW-1:0]    hold_data_q, hold_data_d;
  logic [CSW-1:0]   hold_cs_q, hold_cs_d;
  logic [DW-1:0]    tx_q, tx_d, rx_q, rx_d;
  logic [CSW-1:0]   cs_q, cs_d;
  logic [BW-1:0]    bit_q, bit_d;
  logic             ph_q, ph_d;
  logic [GAP_W-1:0] gcnt_q, gcnt_d;
  logic             last_half, gap_end, start, hold_we;

  assign last_half = (st_q == ST_SHIFT) && half_tick && ph_q && (bit_q == BW'(DW - 1));
  assign gap_end   = (st_q == ST_GAP) && (gcnt_q == '0);
  assign start     = enable && hold_vld_q &&
                     ((st_q == ST_IDLE) || (last_half && (gap_dly == '0)) || gap_end);
  // A full holding register only takes a write on the edge it empties.
  assign hold_we   = wr_en && (!hold_vld_q || start);

  always_comb begin
    st_d        = st_q;
    hold_vld_d  = hold_vld_q;
    hold_data_d = hold_data_q;
    hold_cs_d   = hold_cs_q;
    tx_d        = tx_q;
    rx_d        = rx_q;
    cs_d        = cs_q;
    bit_d       = bit_q;
    ph_d        = ph_q;
    gcnt_d      = gcnt_q;

    if (start) hold_vld_d = 1'b0;
    if (hold_we) begin
      hold_vld_d  = 1'b1;
      hold_data_d = wr_data;
      hold_cs_d   = wr_cs;
    end

    case (st_q)
      ST_IDLE: ;
      ST_SHIFT: begin
        if (half_tick) begin
          if (!ph_q) begin
            // leading edge: capture MISO
            rx_d = {rx_q[DW-2:0], miso};
            ph_d = 1'b1;
          end else begin
            // trailing edge: next bit out or finish
            ph_d = 1'b0;
            if (bit_q == BW'(DW - 1)) begin
              if (gap_dly != '0) begin
                st_d   = ST_GAP;
                gcnt_d = gap_dly - GAP_W'(1);
              end else begin
                st_d = ST_IDLE;
              end
            end else begin
              bit_d = bit_q + BW'(1);
              tx_d  = {tx_q[DW-2:0], 1'b0};
            end
          end
        end
      end
      ST_GAP: begin
        if (gcnt_q == '0) st_d = ST_IDLE;
        else              gcnt_d = gcnt_q - GAP_W'(1);
      end
      default: st_d = ST_IDLE;
    endcase

    if (start) begin
      st_d  = ST_SHIFT;
      tx_d  = hold_data_q;
      cs_d  = hold_cs_q;
      bit_d = '0;
      ph_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      hold_vld_q  <= 1'b0;
      hold_data_q <= '0;
      hold_cs_q   <= '0;
      tx_q        <= '0;
      rx_q        <= '0;
      cs_q        <= '0;
      bit_q       <= '0;
      ph_q        <= 1'b0;
      gcnt_q      <= '0;
    end else begin
      st_q        <= st_d;
      hold_vld_q  <= hold_vld_d;
      hold_data_q <= hold_data_d;
      hold_cs_q   <= hold_cs_d;
      tx_q        <= tx_d;
      rx_q        <= rx_d;
      cs_q        <= cs_d;
      bit_q       <= bit_d;
      ph_q        <= ph_d;
      gcnt_q      <= gcnt_d;
    end
  end

  assign shifting  = (st_q == ST_SHIFT);
  assign phase     = ph_q;
  assign mosi      = tx_q[DW-1];
  assign cur_cs    = cs_q;
  assign thr_empty = !hold_vld_q;
  assign tx_idle   = (st_q == ST_IDLE) && !hold_vld_q;
  assign push      = last_half;
  assign push_data = rx_q;
  assign push_cs   = cs_q;

endmodule

// File: rtl/spi_buf_master.sv
module spi_buf_master #(
  parameter int DATA_W  = 8,
  parameter int CS_W    = 2,
  parameter int DIV_W   = 8,
  parameter int GAP_W   = 8,
  parameter int RX_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 cpol,
  input  logic [DIV_W-1:0]     clk_div,
  input  logic [GAP_W-1:0]     gap_dly,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [CS_W-1:0]      wr_cs,
  input  logic                 rd_en,
  input  logic                 stat_rd,
  output logic [DATA_W-1:0]    rd_data,
  output logic [CS_W-1:0]      rd_cs,
  output logic                 thr_empty,
  output logic                 tx_idle,
  output logic                 rx_avail,
  output logic                 overrun,
  output logic                 sck,
  output logic                 mosi,
  input  logic                 miso,
  output logic [2**CS_W-1:0]   cs_n
);

  localparam int NUM_CS = 2 ** CS_W;
  localparam int ENT_W  = DATA_W + CS_W;

  logic [1:0]        rst_pipe_q;
  logic              rst_core_n;
  logic              half_tick, shifting, phase, push;
  logic [CS_W-1:0]   cur_cs, push_cs;
  logic [DATA_W-1:0] push_data;
  logic [ENT_W-1:0]  head;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  spi_bm_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .run       (shifting),
    .div       (clk_div),
    .half_tick (half_tick)
  );

  spi_bm_engine #(.DW(DATA_W), .CSW(CS_W), .GAP_W(GAP_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .enable    (enable),
    .half_tick (half_tick),
    .miso      (miso),
    .gap_dly   (gap_dly),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wr_cs     (wr_cs),
    .shifting  (shifting),
    .phase     (phase),
    .mosi      (mosi),
    .cur_cs    (cur_cs),
    .thr_empty (thr_empty),
    .tx_idle   (tx_idle),
    .push      (push),
    .push_data (push_data),
    .push_cs   (push_cs)
  );

  spi_bm_rxfifo #(.DEPTH(RX_DEPTH), .EW(ENT_W)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .push      (push),
    .push_ent  ({push_cs, push_data}),
    .pop       (rd_en),
    .clr_ovr   (stat_rd),
    .head      (head),
    .not_empty (rx_avail),
    .ovr       (overrun)
  );

  assign rd_data = head[DATA_W-1:0];
  assign rd_cs   = head[ENT_W-1:DATA_W];
  assign sck     = cpol ^ (shifting & phase);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_csel
    assign cs_n[i] = !(shifting && (cur_cs == CS_W'(i)));
  end

endmodule

// File: rtl/spi_buf_master_chk.sv
module spi_buf_master_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cpol,
  input logic           wr_en,
  input logic           rd_en,
  input logic           stat_rd,
  input logic           thr_empty,
  input logic           tx_idle,
  input logic           rx_avail,
  input logic           overrun,
  input logic           sck,
  input logic           mosi,
  input logic [NCS-1:0] cs_n
);

  // R3: idle serial clock sits at the polarity level
  a_r3_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> (sck == cpol));

  // R6: a captured write empties nothing; holding register reports full next
  a_r6_thr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && thr_empty) |=> !thr_empty);

  // R7: full idle implies no pending byte and no selected slave
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> (thr_empty && (&cs_n)));

  // R8: entries never vanish without a pop
  a_r8_avail_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_avail && !rd_en) |=> rx_avail);

  // R9: overrun stays until a status read
  a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !stat_rd) |=> overrun);

  // R9: overrun can only rise when the FIFO held data
  a_r9_ovr_from_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_avail));

  // R2: MOSI holds while the serial clock stays at its active level
  a_r2_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&cs_n) && (sck != cpol) && $past(!(&cs_n)) && ($past(sck) != $past(cpol)))
      |-> $stable(mosi));

  // R10: chip selects only switch with the clock at idle level
  a_r10_cs_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&cs_n) && $past(!(&cs_n)) && (sck != cpol)) |-> $stable(cs_n));

endmodule

bind spi_buf_master spi_buf_master_chk #(.NCS(NUM_CS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpol      (cpol),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .stat_rd   (stat_rd),
  .thr_empty (thr_empty),
  .tx_idle   (tx_idle),
  .rx_avail  (rx_avail),
  .overrun   (overrun),
  .sck       (sck),
  .mosi      (mosi),
  .cs_n      (cs_n)
);

// File: tb/spi_buf_master_test.sv
`timescale 1ns/1ps
module spi_buf_master_test;

  logic       clk, rst_n, enable, cpol, wr_en, rd_en, stat_rd, miso;
  logic [7:0] clk_div, gap_dly, wr_data, rd_data;
  logic [1:0] wr_cs, rd_cs;
  logic       thr_empty, tx_idle, rx_avail, overrun, sck, mosi;
  logic [3:0] cs_n;

  int n_chk, n_fail, e;
  logic rst_done;

  spi_buf_master uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cpol(cpol), .clk_div(clk_div),
    .gap_dly(gap_dly), .wr_en(wr_en), .wr_data(wr_data), .wr_cs(wr_cs),
    .rd_en(rd_en), .stat_rd(stat_rd), .rd_data(rd_data), .rd_cs(rd_cs),
    .thr_empty(thr_empty), .tx_idle(tx_idle), .rx_avail(rx_avail),
    .overrun(overrun), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] sb(input int i);
    return 8'((i * 73 + 29) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Slave model: shifts on trailing edges, captures MOSI on leading edges.
  logic       prv_sck, prv_cpol;
  int         s_lead, s_trail, slv_idx;
  logic [7:0] s_sr, s_cap;
  logic [7:0] mosi_log [0:255];

  always @(negedge clk) begin
    logic lead, trail, act;
    act   = !(&cs_n);
    lead  = rst_done && (cpol == prv_cpol) && (sck != prv_sck) && (sck != cpol);
    trail = rst_done && (cpol == prv_cpol) && (sck != prv_sck) && (sck == cpol);
    if (lead) begin
      s_cap = {s_cap[6:0], mosi};
      s_lead++;
      if (s_lead == 8) begin
        mosi_log[slv_idx % 256] = s_cap;
        s_lead = 0;
      end
    end
    if (trail) begin
      s_trail++;
      if (s_trail == 8) begin
        s_trail = 0;
        slv_idx++;
      end
    end
    if (!act) s_sr = sb(slv_idx);
    else if (trail) begin
      if (s_trail == 0) s_sr = sb(slv_idx);
      else              s_sr = {s_sr[6:0], 1'b0};
    end
    miso     = s_sr[7];
    prv_sck  = sck;
    prv_cpol = cpol;
  end

  task automatic wr(input logic [7:0] d, input logic [1:0] c);
    wr_en = 1'b1; wr_data = d; wr_cs = c;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    @(negedge clk);
    while (!tx_idle && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic one_xfer(input logic cp, input int dv, input int gp, input int c);
    logic [7:0] d;
    logic [3:0] msk;
    int h, n, bad, g;
    cpol = cp; clk_div = 8'(dv); gap_dly = 8'(gp);
    @(negedge clk);
    d   = 8'((e * 29 + 3) & 255);
    msk = ~(4'b0001 << c);
    h   = (dv == 0) ? 1 : dv;
    wr(d, 2'(c));
    chk("R6 thr_empty after write", int'(thr_empty), 0);
    chk("R1 no select before load", int'(cs_n), 15);
    @(negedge clk);
    chk("R6 thr_empty after load", int'(thr_empty), 1);
    chk("R1 select on load", int'(cs_n), int'(msk));
    n = 0; bad = 0;
    while (cs_n != 4'hF && n < 5000) begin
      if (cs_n != msk) bad++;
      n++;
      @(negedge clk);
    end
    chk("R10 single select held", bad, 0);
    chk("R2 select low length", n, 16 * h);
    g = 0;
    while (!tx_idle && g < 1000) begin g++; @(negedge clk); end
    chk("R7 idle delay", g, gp);
    chk("R3 idle sck level", int'(sck), int'(cp));
    chk("R2 mosi byte", int'(mosi_log[e % 256]), int'(d));
    chk("R8 avail", int'(rx_avail), 1);
    chk("R8 rx data", int'(rd_data), int'(sb(e)));
    chk("R8 rx code", int'(rd_cs), c);
    pop();
    chk("R8 empty after pop", int'(rx_avail), 0);
    e++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    n_chk = 0; n_fail = 0; e = 0; rst_done = 1'b0;
    prv_sck = 1'b0; prv_cpol = 1'b0; s_lead = 0; s_trail = 0; slv_idx = 0;
    s_sr = 8'h00; s_cap = 8'h00; miso = 1'b0;
    rst_n = 1'b0; enable = 1'b0; cpol = 1'b0; clk_div = 8'd0; gap_dly = 8'd0;
    wr_en = 1'b0; wr_data = 8'h00; wr_cs = 2'd0; rd_en = 1'b0; stat_rd = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rst_done = 1'b1;

    chk("R6 reset thr_empty", int'(thr_empty), 1);
    chk("R7 reset tx_idle", int'(tx_idle), 1);
    chk("R8 reset rx_avail", int'(rx_avail), 0);
    chk("R9 reset overrun", int'(overrun), 0);
    chk("R10 reset cs_n", int'(cs_n), 15);
    chk("R3 reset sck", int'(sck), 0);
    enable = 1'b1;

    // Sweep polarity, divisor, gap and chip-select code.
    for (int cp = 0; cp < 2; cp++)
      for (int di = 0; di < 3; di++)
        for (int gp = 0; gp < 4; gp += 3)
          for (int c = 0; c < 4; c++)
            one_xfer(cp[0], (di == 2) ? 3 : di, gp, c);

    // R4: chained transfers, same code, no gap.
    cpol = 1'b1; clk_div = 8'd2; gap_dly = 8'd0;
    @(negedge clk);
    wr(8'hA5, 2'd1);
    @(negedge clk);
    wr(8'h3C, 2'd1);
    chk("R4 second byte waits", int'(thr_empty), 0);
    n = 0;
    while (cs_n == 4'b1101 && n < 5000) begin n++; @(negedge clk); end
    chk("R4 continuous select", n + 1, 64);
    chk("R4 idle right after", int'(tx_idle), 1);
    chk("R4 first byte", int'(mosi_log[e % 256]), 8'hA5);
    chk("R4 second byte", int'(mosi_log[(e + 1) % 256]), 8'h3C);
    chk("R4 rx first", int'(rd_data), int'(sb(e)));
    pop();
    chk("R4 rx second", int'(rd_data), int'(sb(e + 1)));
    pop();
    e += 2;

    // R5: write into a full holding register is dropped.
    cpol = 1'b0; clk_div = 8'd4; gap_dly = 8'd0;
    @(negedge clk);
    wr(8'h11, 2'd2);
    @(negedge clk);
    wr(8'h22, 2'd3);
    wr(8'h33, 2'd0);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R5 transfer count", slv_idx, e + 2);
    chk("R5 held byte sent", int'(mosi_log[(e + 1) % 256]), 8'h22);
    chk("R5 rx code a", int'(rd_cs), 2);
    pop();
    chk("R5 rx code b", int'(rd_cs), 3);
    pop();
    chk("R5 nothing extra", int'(rx_avail), 0);
    e += 2;

    // R1: disabled block keeps the byte waiting.
    enable = 1'b0; clk_div = 8'd1;
    @(negedge clk);
    wr(8'h5A, 2'd1);
    n = 0;
    repeat (20) begin if (cs_n != 4'hF) n++; @(negedge clk); end
    chk("R1 no transfer while disabled", n, 0);
    chk("R1 byte waiting", int'(thr_empty), 0);
    chk("R7 not idle with byte waiting", int'(tx_idle), 0);
    enable = 1'b1;
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R1 byte sent after enable", int'(mosi_log[e % 256]), 8'h5A);
    chk("R1 rx after enable", int'(rd_data), int'(sb(e)));
    pop();
    e++;

    // R9: five arrivals with nothing read.
    clk_div = 8'd1; gap_dly = 8'd1;
    @(negedge clk);
    for (int j = 0; j < 5; j++) begin
      wr(8'((j * 41 + 7) & 255), 2'(j % 4));
      wait_idle();
      if (j == 3) chk("R9 no overrun at four", int'(overrun), 0);
    end
    chk("R9 overrun set", int'(overrun), 1);
    repeat (5) @(negedge clk);
    chk("R9 overrun sticky", int'(overrun), 1);
    for (int j = 0; j < 4; j++) begin
      chk("R9 kept data", int'(rd_data), int'(sb(e + j)));
      chk("R9 kept code", int'(rd_cs), j % 4);
      pop();
    end
    chk("R9 fifth dropped", int'(rx_avail), 0);
    chk("R9 pop keeps flag", int'(overrun), 1);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    chk("R9 cleared by status read", int'(overrun), 0);
    e += 5;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule